// File: doc/BRIEF.md
# Protected Control Register Unlock Sequencer

This block holds a 16-bit control register made of two independently protected byte lanes. A bus write to either byte takes effect only when it lands in a one-instruction window, opened by writing a two-value key to that same byte on back-to-back instructions. Key writes leave the register contents alone. Any other instruction that falls between the two keys, or between the second key and the data write, cancels the unlock.

Instructions are counted with an "instruction issued" strobe. Cycles where this strobe is low are stall cycles, and nothing changes in them. Each lane runs its own three-state sequencer with the states idle, first-key-seen and window-open. A write to a protected byte that neither advances its key sequence nor falls in an open window is dropped. Such a write also raises a sticky error flag, which only reset clears.

Top module: `unlock_reg`

## Requirements
- R1: After reset, `ctrl_q` equals the RST_VAL parameter (default 16'h0000), both windows are closed and `seq_err` is 0.
- R2: Writing 8'h46 and then 8'h57 to the low byte (`wr_hi`=0) on consecutive instructions raises `win_lo` after the second key's clock edge.
- R3: Writing 8'h78 and then 8'h9A to the high byte (`wr_hi`=1) on consecutive instructions raises `win_hi` after the second key's clock edge.
- R4: While a lane's window is open, the next instruction closes it. If that instruction writes the same lane, its data (any value, keys included) is loaded into that byte of `ctrl_q`.
- R5: An instruction that is not a write to the lane in question voids that lane's sequence or window. This covers an instruction with no write as well as a write to the other lane.
- R6: A write of a wrong value during the sequence returns the lane to idle. A write equal to the first key, arriving in any state other than window-open, restarts the sequence at first-key-seen.
- R7: Key writes never change `ctrl_q`.
- R8: A write to one lane never changes the other byte of `ctrl_q`, and the two windows are never open together.
- R9: When `insn_valid` is 0, nothing changes: no state, register, window or error flag. This holds even if `wr_en` is 1.
- R10: A write to a protected byte that is not accepted as a key step or as window data is ignored and sets `seq_err`. The flag then stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn_valid | input | 1 | An instruction is issued this cycle |
| wr_en | input | 1 | Bus byte write strobe |
| wr_hi | input | 1 | Byte lane select: 0 low byte, 1 high byte |
| wr_data | input | 8 | Write data |
| win_lo | output | 1 | Low-byte write window open |
| win_hi | output | 1 | High-byte write window open |
| ctrl_q | output | 16 | Protected register contents |
| seq_err | output | 1 | Sticky flag for a rejected protected write |

## Verification
A lane sequencer stuck in the wrong state shows up at the port one instruction later. A window opens when it should not, stays shut after a correct key pair, or lingers past the instruction that should close it. A wrong transition that does not touch the window becomes visible one cycle after the next write to that lane. In that cycle either the byte takes a value it should have rejected, or `seq_err` rises (or fails to rise). For this reason the bench compares all outputs against a behavioural model after every clock. It also places data writes directly behind each kind of broken or restarted key sequence.

// File: rtl/unlock_reg.sv
module unlock_reg #(
  parameter logic [7:0]  LO_KEY1 = 8'h46,
  parameter logic [7:0]  LO_KEY2 = 8'h57,
  parameter logic [7:0]  HI_KEY1 = 8'h78,
  parameter logic [7:0]  HI_KEY2 = 8'h9A,
  parameter logic [15:0] RST_VAL = 16'h0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        insn_valid,
  input  logic        wr_en,
  input  logic        wr_hi,
  input  logic [7:0]  wr_data,
  output logic        win_lo,
  output logic        win_hi,
  output logic [15:0] ctrl_q,
  output logic        seq_err
);
  typedef enum logic [1:0] {S_IDLE, S_KEY1, S_OPEN} lane_st_t;

  logic [1:0] open_v;
  logic [1:0] bad_v;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    localparam logic [7:0] K1  = (g == 0) ? LO_KEY1 : HI_KEY1;
    localparam logic [7:0] K2  = (g == 0) ? LO_KEY2 : HI_KEY2;
    localparam logic       SEL = 1'(g);

    lane_st_t   st_q, st_d;
    logic [7:0] byte_q;
    logic       hit, bad;

    assign hit = insn_valid && wr_en && (wr_hi == SEL);

    always_comb begin
      st_d = st_q;
      bad  = 1'b0;
      if (insn_valid) begin
        if (!hit)                              st_d = S_IDLE;
        else if (st_q == S_OPEN)               st_d = S_IDLE;
        else if (st_q == S_KEY1 && wr_data == K2) st_d = S_OPEN;
        else if (wr_data == K1)                st_d = S_KEY1;
        else begin
          st_d = S_IDLE;
          bad  = 1'b1;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q   <= S_IDLE;
        byte_q <= RST_VAL[g*8 +: 8];
      end else begin
        st_q <= st_d;
        if (hit && st_q == S_OPEN) byte_q <= wr_data;
      end
    end

    assign ctrl_q[g*8 +: 8] = byte_q;
    assign open_v[g]        = (st_q == S_OPEN);
    assign bad_v[g]         = bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seq_err <= 1'b0;
    else        seq_err <= seq_err | (|bad_v);
  end

  assign win_lo = open_v[0];
  assign win_hi = open_v[1];
endmodule

module unlock_reg_chk #(
  parameter logic [7:0] LO_KEY2 = 8'h57,
  parameter logic [7:0] HI_KEY2 = 8'h9A
) (
  input logic        clk,
  input logic        rst_n,
  input logic        insn_valid,
  input logic        wr_en,
  input logic        wr_hi,
  input logic [7:0]  wr_data,
  input logic        win_lo,
  input logic        win_hi,
  input logic [15:0] ctrl_q,
  input logic        seq_err
);
  p_lo_open_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_lo) |-> $past(insn_valid && wr_en && !wr_hi && wr_data == LO_KEY2));

  p_hi_open_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_hi) |-> $past(insn_valid && wr_en && wr_hi && wr_data == HI_KEY2));

  p_lo_window_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    win_lo && insn_valid |=> !win_lo);

  p_hi_window_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    win_hi && insn_valid |=> !win_hi);

  p_lo_byte_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !win_lo |=> $stable(ctrl_q[7:0]));

  p_hi_byte_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !win_hi |=> $stable(ctrl_q[15:8]));

  p_one_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(win_lo && win_hi));

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid |=> $stable(ctrl_q) && $stable(win_lo) && $stable(win_hi) && $stable(seq_err));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> seq_err);
endmodule

bind unlock_reg unlock_reg_chk #(.LO_KEY2(LO_KEY2), .HI_KEY2(HI_KEY2)) u_chk (.*);

// File: tb/unlock_reg_bench.sv
module unlock_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_valid = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_hi = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        win_lo, win_hi, seq_err;
  logic [15:0] ctrl_q;

  int checks = 0;
  int errors = 0;

  int         m_st [2];
  logic [7:0] m_byte [2];
  logic       m_err;
  logic [7:0] key_a [2] = '{8'h46, 8'h78};
  logic [7:0] key_b [2] = '{8'h57, 8'h9A};

  unlock_reg u_unlock_reg (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .wr_en(wr_en),
    .wr_hi(wr_hi), .wr_data(wr_data), .win_lo(win_lo), .win_hi(win_hi),
    .ctrl_q(ctrl_q), .seq_err(seq_err)
  );

  always #10 clk = ~clk;

  task automatic model_edge();
    if (!insn_valid) return;
    for (int l = 0; l < 2; l++) begin
      if (!(wr_en && (int'(wr_hi) == l))) m_st[l] = 0;
      else if (m_st[l] == 2) begin
        m_byte[l] = wr_data;
        m_st[l] = 0;
      end else if (m_st[l] == 1 && wr_data == key_b[l]) m_st[l] = 2;
      else if (wr_data == key_a[l]) m_st[l] = 1;
      else begin
        m_st[l] = 0;
        m_err = 1'b1;
      end
    end
  endtask

  task automatic compare(input string tag);
    logic [15:0] eq;
    logic        el, eh;
    eq = {m_byte[1], m_byte[0]};
    el = (m_st[0] == 2);
    eh = (m_st[1] == 2);
    checks++;
    if (ctrl_q !== eq || win_lo !== el || win_hi !== eh || seq_err !== m_err) begin
      errors++;
      $display("FAIL %s: q=%h win=%b%b err=%b expected q=%h win=%b%b err=%b",
               tag, ctrl_q, win_hi, win_lo, seq_err, eq, eh, el, m_err);
    end
  endtask

  task automatic step(input logic iv, input logic en, input logic hi,
                      input logic [7:0] d, input string tag);
    insn_valid = iv; wr_en = en; wr_hi = hi; wr_data = d;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic wr(input logic hi, input logic [7:0] d, input string tag);
    step(1'b1, 1'b1, hi, d, tag);
  endtask

  task automatic nop(input string tag);
    step(1'b1, 1'b0, 1'b0, 8'h00, tag);
  endtask

  task automatic stall(input logic en, input logic [7:0] d, input string tag);
    step(1'b0, en, 1'b0, d, tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; insn_valid = 1'b0; wr_en = 1'b0;
    for (int l = 0; l < 2; l++) begin
      m_st[l] = 0;
      m_byte[l] = 8'h00;
    end
    m_err = 1'b0;
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after release");
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R2 R4 R7: low unlock then data
    wr(0, 8'h46, "R2 key1"); wr(0, 8'h57, "R2 key2"); wr(0, 8'hA5, "R4 low data");
    // R3 R4 R8: high unlock then data
    wr(1, 8'h78, "R3 key1"); wr(1, 8'h9A, "R3 key2"); wr(1, 8'h3C, "R8 high data");
    // R9: stalls inside the sequence, ghost writes ignored
    wr(0, 8'h46, "R9 key1"); stall(1, 8'h11, "R9 stall"); wr(0, 8'h57, "R9 key2");
    stall(1, 8'h22, "R9 stall open"); stall(0, 8'h00, "R9 idle");
    wr(0, 8'h5A, "R9 data after stalls");
    // R5 R10: nop between keys voids
    wr(0, 8'h46, "R5 key1"); nop("R5 nop"); wr(0, 8'h57, "R10 stray key2");
    wr(0, 8'hFF, "R10 ignored write");
    // R5 R8: other-lane write between keys
    wr(0, 8'h46, "R5 key1"); wr(1, 8'h78, "R8 other lane"); wr(0, 8'h57, "R5 broken");
    wr(0, 8'h01, "R5 rejected");
    // R6: wrong value, then restart via repeated key1
    wr(1, 8'h78, "R6 key1"); wr(1, 8'h11, "R6 wrong"); wr(1, 8'h9A, "R6 late key2");
    wr(1, 8'h78, "R6 key1"); wr(1, 8'h78, "R6 restart"); wr(1, 8'h9A, "R6 key2");
    wr(1, 8'h81, "R6 data after restart");
    // R4 R5: window closes after one intervening instruction
    wr(0, 8'h46, "R4 key1"); wr(0, 8'h57, "R4 key2"); nop("R4 close");
    wr(0, 8'h77, "R4 late data");
    // R4 R7: key value as window data, keys leave register alone
    wr(0, 8'h46, "R7 key1"); wr(0, 8'h57, "R7 key2"); wr(0, 8'h46, "R4 key value data");
    wr(0, 8'h57, "R10 after window");
    // R3 window closed by low write
    wr(1, 8'h78, "R3 key1"); wr(1, 8'h9A, "R3 key2"); wr(0, 8'h12, "R8 cross close");
    wr(1, 8'h34, "R8 high rejected");
    // R1: reset clears flag and register
    do_reset();
    wr(1, 8'h78, "R3 post reset"); wr(1, 8'h9A, "R3 post reset key2");
    wr(1, 8'hC3, "R4 post reset data");
    nop("R10 clean");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule